// File: doc/BRIEF.md
# Multi-port status word serializer

This block streams the status of several ports over a single serial data line. Every frame opens with a delimiter of sixteen consecutive ones. One 16-bit status word per port follows, lowest port first. The next frame starts right after the last word, with no gap. A receiver needs only the data line and the shared serial clock to find frames and read them. That clock comes from outside the block and runs at up to 25 MHz. Several serializers can share one clock source.

All logic advances on the falling edge of the serial clock. The parallel status inputs are copied into a shadow bank at the edge that starts a frame, so each frame carries one coherent set of words. The top and bottom bit of every data word are always sent as zero. The longest run of ones inside the data is therefore fourteen, and data can never look like the delimiter.

Top module: `stw_serializer`

## Requirements
- R1: With `rst` high at a falling edge, the block returns to the first bit of a delimiter, and `ser_out` is 1 until the following falling edge. The first frame after reset is a complete frame.
- R2: Each frame begins with 16 bits that are all 1.
- R3: After the delimiter come N words, sent in the order port 0, port 1, and so on up to port N-1. Port p's word is taken from `port_status[16*p+15 : 16*p]`.
- R4: The bits of each word are sent from bit 15 down to bit 0.
- R5: Bit 15 and bit 0 of every transmitted word are 0, whatever the input value. Bits 14 down to 1 are sent unchanged.
- R6: A frame is exactly (N+1)*16 bits long. The next delimiter follows the last bit of port N-1's word with no idle bit between them.
- R7: `port_status` is sampled only at a falling edge that starts a frame, or at any falling edge where `rst` is high. Changes at any other time do not affect the frame already being sent.
- R8: `ser_out` changes only just after a falling edge of `ser_clk`. It is stable between a rising edge and the next falling edge.
- R9: `ser_out` is never 1 for more than 16 consecutive bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk | input | 1 | Externally supplied serial clock; state advances on its falling edge |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge |
| port_status | input | 16*N | Parallel status words, port p in bits 16*p+15 down to 16*p |
| ser_out | output | 1 | Serial data: delimiter, then one word per port |

## Verification
Two events can fall on the same falling edge: the snapshot load at the frame boundary and a change of the parallel inputs. The bench changes `port_status` in the cycle just before the wrap edge, so the new value must appear in the frame that is starting. It also changes the inputs at random points inside a frame, and those changes must appear only one frame later. Reset pulses are placed in the middle of frames, so that reset and an ongoing word can collide. After each pulse the stream must restart at a fresh delimiter with freshly sampled words. Every bit is compared against a frame model built from the requirements, with inputs set to all ones to stress the forced-zero bits and the limit on runs of ones.

// File: rtl/stw_pkg.sv
package stw_pkg;

    localparam int WORD_W = 16;
    localparam int BIT_W  = $clog2(WORD_W);

    typedef enum logic {
        PH_DELIM = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [BIT_W-1:0]   bit_idx;
    } pos_t;

    // Clear the outer bits of a data word so no run of ones can reach delimiter length.
    function automatic logic [WORD_W-1:0] guard_word(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] g;
        g            = w;
        g[WORD_W-1]  = 1'b0;
        g[0]         = 1'b0;
        return g;
    endfunction

endpackage

// File: rtl/stw_frame_seq.sv
module stw_frame_seq
    import stw_pkg::*;
#(
    parameter int N      = 4,
    parameter int SLOT_W = $clog2(N + 1)
) (
    input  logic              ser_clk,
    input  logic              rst,
    output pos_t              pos,
    output logic [SLOT_W-1:0] slot,
    output logic              load_snap
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);

    logic [BIT_W-1:0]  bit_q;
    logic [SLOT_W-1:0] slot_q;
    logic              wrap;

    assign wrap      = (bit_q == LAST_BIT) && (slot_q == LAST_SLOT);
    assign load_snap = rst || wrap;

    always_ff @(negedge ser_clk) begin
        if (rst) begin
            bit_q  <= '0;
            slot_q <= '0;
        end else if (bit_q == LAST_BIT) begin
            bit_q  <= '0;
            slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
        end else begin
            bit_q  <= bit_q + 1'b1;
        end
    end

    assign slot        = slot_q;
    assign pos.bit_idx = bit_q;
    assign pos.phase   = (slot_q == '0) ? PH_DELIM : PH_DATA;

endmodule

// File: rtl/stw_snap_bank.sv
module stw_snap_bank
    import stw_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                ser_clk,
    input  logic                load,
    input  logic [N*WORD_W-1:0] words_in,
    output logic [N*WORD_W-1:0] shadow
);

    for (genvar p = 0; p < N; p++) begin : g_port
        logic [WORD_W-1:0] word_q;

        always_ff @(negedge ser_clk) begin
            if (load) begin
                word_q <= guard_word(words_in[p*WORD_W +: WORD_W]);
            end
        end

        assign shadow[p*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/stw_bit_sel.sv
module stw_bit_sel
    import stw_pkg::*;
#(
    parameter int N      = 4,
    parameter int SLOT_W = $clog2(N + 1)
) (
    input  pos_t                pos,
    input  logic [SLOT_W-1:0]   slot,
    input  logic [N*WORD_W-1:0] shadow,
    output logic                bit_out
);

    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(WORD_W - 1);

    logic [WORD_W-1:0] cur_word;

    always_comb begin
        cur_word = '0;
        for (int p = 0; p < N; p++) begin
            if (slot == SLOT_W'(p + 1)) begin
                cur_word = shadow[p*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        if (pos.phase == PH_DELIM) begin
            bit_out = 1'b1;
        end else begin
            bit_out = cur_word[TOP_BIT - pos.bit_idx];
        end
    end

endmodule

// File: rtl/stw_serializer.sv
module stw_serializer
    import stw_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                ser_clk,
    input  logic                rst,
    input  logic [N*WORD_W-1:0] port_status,
    output logic                ser_out
);

    localparam int SLOT_W = $clog2(N + 1);

    pos_t                pos;
    logic [SLOT_W-1:0]   slot;
    logic                load_snap;
    logic [N*WORD_W-1:0] shadow_flat;

    stw_frame_seq #(.N(N), .SLOT_W(SLOT_W)) u_seq (
        .ser_clk   (ser_clk),
        .rst       (rst),
        .pos       (pos),
        .slot      (slot),
        .load_snap (load_snap)
    );

    stw_snap_bank #(.N(N)) u_bank (
        .ser_clk  (ser_clk),
        .load     (load_snap),
        .words_in (port_status),
        .shadow   (shadow_flat)
    );

    stw_bit_sel #(.N(N), .SLOT_W(SLOT_W)) u_sel (
        .pos     (pos),
        .slot    (slot),
        .shadow  (shadow_flat),
        .bit_out (ser_out)
    );

endmodule

// File: rtl/stw_serializer_chk.sv
module stw_serializer_chk
    import stw_pkg::*;
#(
    parameter int N = 4
) (
    input logic                ser_clk,
    input logic                rst,
    input logic                ser_out,
    input logic                load_snap,
    input logic [N*WORD_W-1:0] shadow
);

    localparam int FRAME = (N + 1) * WORD_W;
    localparam int CW    = $clog2(FRAME);
    localparam int RW    = $clog2(FRAME + 1);

    logic [CW-1:0] cnt;
    logic [RW-1:0] run;

    always_ff @(negedge ser_clk) begin
        if (rst) begin
            cnt <= '0;
            run <= '0;
        end else begin
            cnt <= (cnt == CW'(FRAME - 1)) ? '0 : cnt + 1'b1;
            run <= ser_out ? run + 1'b1 : '0;
        end
    end

    // R2: the first sixteen bit times of a frame are ones
    p_delim_ones_r2: assert property (@(negedge ser_clk) disable iff (rst)
        (cnt < CW'(WORD_W)) |-> ser_out);

    // R5: the top bit of each data word is zero
    p_guard_top_r5: assert property (@(negedge ser_clk) disable iff (rst)
        ((cnt >= CW'(WORD_W)) && (cnt[3:0] == 4'd0)) |-> !ser_out);

    // R5: the bottom bit of each data word is zero
    p_guard_bot_r5: assert property (@(negedge ser_clk) disable iff (rst)
        ((cnt >= CW'(WORD_W)) && (cnt[3:0] == 4'd15)) |-> !ser_out);

    // R9: no run of ones longer than a delimiter
    p_run_limit_r9: assert property (@(negedge ser_clk) disable iff (rst)
        ser_out |-> (run < RW'(WORD_W)));

    // R6: the frame wraps, and the snapshot loads, after exactly FRAME bits
    p_wrap_load_r6: assert property (@(negedge ser_clk) disable iff (rst)
        (cnt == CW'(FRAME - 1)) |-> load_snap);

    // R7: outside the frame boundary the shadow words hold their value
    p_snap_hold_r7: assert property (@(negedge ser_clk) disable iff (rst)
        !load_snap |=> $stable(shadow));

endmodule

bind stw_serializer stw_serializer_chk #(.N(N)) u_chk (
    .ser_clk   (ser_clk),
    .rst       (rst),
    .ser_out   (ser_out),
    .load_snap (load_snap),
    .shadow    (shadow_flat)
);

// File: tb/sim_stw_serializer.sv
module sim_stw_serializer;

    localparam int N     = 4;
    localparam int W     = 16;
    localparam int FRAME = (N + 1) * W;
    localparam int NCYC  = 4000;

    logic             clk;
    logic             rst;
    logic [N*W-1:0]   words;
    logic             sdat;

    int checks = 0;
    int errors = 0;

    stw_serializer #(.N(N)) u0 (
        .ser_clk     (clk),
        .rst         (rst),
        .port_status (words),
        .ser_out     (sdat)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Expected bit at frame position m for a snapshot of raw input words.
    function automatic logic exp_bit(input int m, input logic [N*W-1:0] snap);
        int p;
        int b;
        logic [W-1:0] w;
        if (m < W) return 1'b1;
        p = m / W - 1;
        b = W - 1 - (m % W);
        w = snap[p*W +: W];
        if (b == W - 1 || b == 0) return 1'b0;
        return w[b];
    endfunction

    function automatic logic [N*W-1:0] rand_words();
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
        return v;
    endfunction

    task automatic check(input string tag, input logic act, input logic expv, input int m);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s pos=%0d actual=%0b expected=%0b", tag, m, act, expv);
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int             m;
        logic [N*W-1:0] snap;
        logic           valid;
        logic           first_frame;
        int             run;
        logic           s0;
        logic           e;
        string          tag;

        void'($urandom(32'h5EED_1234));
        rst         = 1'b1;
        words       = '0;
        m           = 0;
        snap        = '0;
        valid       = 1'b0;
        first_frame = 1'b1;
        run         = 0;

        for (int k = 0; k < NCYC; k++) begin
            @(posedge clk);
            #1;
            if (valid) begin
                s0 = sdat;
                e  = exp_bit(m, snap);
                if (rst) begin
                    tag = "R1";
                end else if (m == 0) begin
                    tag = first_frame ? "R1" : "R6";
                end else if (m < W) begin
                    tag = first_frame ? "R1" : "R2";
                end else if ((m % W) == 0 || (m % W) == W - 1) begin
                    tag = "R5";
                end else if (words != snap) begin
                    tag = "R7";
                end else if ((m % W) < 4) begin
                    tag = "R4";
                end else begin
                    tag = "R3";
                end
                check(tag, s0, e, m);
                run = s0 ? run + 1 : 0;
                if (!rst) check("R9", (run <= W), 1'b1, m);
                #2;
                check("R8", sdat, s0, m);
            end

            // stimulus for the coming falling edge
            rst = (k < 3) || (k == 1500) || (k == 2601) || (k == 2602) || (k == 3333);
            if (k >= 800 && k < 1200) begin
                words = '1;
            end else if (k >= 1200 && k < 2000 && m == FRAME - 1) begin
                words = rand_words();
            end else if (k == 0 || ($urandom % 8) == 0) begin
                words = rand_words();
            end

            // model of the coming falling edge
            if (rst) begin
                m           = 0;
                snap        = words;
                first_frame = 1'b1;
                run         = 0;
            end else begin
                m = (m + 1) % FRAME;
                if (m == 0) begin
                    snap        = words;
                    first_frame = 1'b0;
                end
            end
            valid = 1'b1;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule